// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block takes a serial PHY out of reset and confirms that its receive PLL has settled before the link layer is allowed to use it. It talks to a control-register handshake master through a simple command port. Each command is an address capture, a read or a posted write, and it is held on the port until the master pulses done. In register mode the sequencer selects the PHY clock/reset register and posts a write of its reset bit. The PHY cannot acknowledge that write, so the sequencer does not wait for done on it. It then polls a lane status register a bounded number of times. Before each poll it waits a fixed number of cycles, selects the register and reads it.

Some PHY variants are reset through sideband wires instead of a register write. When the mode input selects sideband operation, the sequencer clears the power-down wire, pulls the active-low software reset wire low, holds it for a programmed number of cycles and releases it. No register traffic takes place in this mode. The outcome is reported on a ready flag or on an error flag with a fault code. Both stay in place until the next accepted start.

Top module: `phy_rst_lock_seq`

## Requirements
- R1: After reset, phy_ready, phy_error and cmd_req are 0, fault_code is 0, sb_pwrdn is 1 and sb_rst_n is 1.
- R2: A start in register mode first issues an address command (cmd_op 2'b00) with cmd_wdata 16'h7F3F and holds it until cmd_done. It then issues a posted write (cmd_op 2'b10) with cmd_wdata 16'h0001 for exactly one cycle and does not wait for cmd_done.
- R3: Each status check is preceded by POLL_CYCLES cycles with cmd_req low, counted from the posted write or from the previous read's done. The check itself is an address command with cmd_wdata 16'h2003 followed by a read command (cmd_op 2'b01, cmd_wdata 16'h0000).
- R4: A read whose cmd_rdata has bit 1 set sets phy_ready with fault_code 0 and ends the sequence; no further command follows. phy_ready and phy_error are never both high.
- R5: If MAX_POLLS reads all return bit 1 clear, the sequence ends with phy_error high and fault_code 2'b01 after exactly MAX_POLLS reads.
- R6: cmd_err high together with cmd_done aborts the sequence in the next cycle: cmd_req drops, phy_error rises and fault_code is 2'b10.
- R7: A start in sideband mode drives sb_pwrdn to 0 and sb_rst_n to 0 in the same cycle. sb_rst_n stays low for exactly SB_CYCLES cycles, and phy_ready rises in the cycle sb_rst_n returns high. No command is issued in this mode, and register mode never changes the sideband wires.
- R8: start is ignored while a sequence is running; the command stream is unchanged by it.
- R9: While a non-posted command waits for cmd_done, cmd_req stays high and cmd_op and cmd_wdata stay stable.
- R10: An accepted start clears phy_ready, phy_error and fault_code in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence when idle |
| sideband_mode | input | 1 | 1 selects the sideband reset, 0 the register reset with PLL poll |
| cmd_req | output | 1 | Command request to the handshake master |
| cmd_op | output | 2 | 00 address capture, 01 read, 10 posted write |
| cmd_wdata | output | 16 | Register address or write data |
| cmd_done | input | 1 | Single-cycle completion from the master |
| cmd_err | input | 1 | Master fault, valid with cmd_done |
| cmd_rdata | input | 16 | Read data, valid with cmd_done |
| phy_ready | output | 1 | Reset finished and PLL stable (or sideband release done) |
| phy_error | output | 1 | Sequence ended in a fault |
| fault_code | output | 2 | 00 none, 01 lock timeout, 10 master fault |
| sb_pwrdn | output | 1 | Sideband power-down wire |
| sb_rst_n | output | 1 | Sideband active-low software reset wire |

## Verification
The bench builds the sequencer with POLL_CYCLES 4, SB_CYCLES 6 and MAX_POLLS 3, and its master model answers after two cycles. With these values the exact poll gap, the full timeout after the last allowed read and lock on that same final read all fall within a few dozen cycles. The short sideband hold lets the release cycle be compared against the rise of ready, and master faults are injected both on the first command and in the middle of polling.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int unsigned REG_W = 16;

    localparam logic [REG_W-1:0] CLKRST_ADDR  = 16'h7F3F;
    localparam logic [REG_W-1:0] CLKRST_RESET = 16'h0001;
    localparam logic [REG_W-1:0] LANE_STAT_ADDR = 16'h2003;
    localparam int unsigned      LOCK_BIT = 1;
    localparam logic [REG_W-1:0] LOCK_MASK = 16'h0001 << LOCK_BIT;

    typedef enum logic [1:0] {
        OP_ADDR      = 2'b00,
        OP_READ      = 2'b01,
        OP_WR_POSTED = 2'b10
    } cmd_op_e;

    typedef enum logic [1:0] {
        FAULT_NONE    = 2'b00,
        FAULT_TIMEOUT = 2'b01,
        FAULT_MASTER  = 2'b10
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST_ADDR,
        S_RST_WR,
        S_WAIT,
        S_STAT_ADDR,
        S_STAT_RD,
        S_SB_HOLD
    } seq_state_e;

    typedef struct packed {
        logic             req;
        cmd_op_e          op;
        logic [REG_W-1:0] data;
    } cmd_t;

    function automatic cmd_t state_cmd(seq_state_e s);
        cmd_t c;
        c = '0;
        case (s)
            S_RST_ADDR: begin
                c.req  = 1'b1;
                c.op   = OP_ADDR;
                c.data = CLKRST_ADDR;
            end
            S_RST_WR: begin
                c.req  = 1'b1;
                c.op   = OP_WR_POSTED;
                c.data = CLKRST_RESET;
            end
            S_STAT_ADDR: begin
                c.req  = 1'b1;
                c.op   = OP_ADDR;
                c.data = LANE_STAT_ADDR;
            end
            S_STAT_RD: begin
                c.req  = 1'b1;
                c.op   = OP_READ;
                c.data = '0;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/phy_seq_delay.sv
module phy_seq_delay #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expired
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign expired = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/phy_seq_tries.sv
module phy_seq_tries #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] FINAL = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign last = (cnt == FINAL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && !last) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/phy_rst_lock_seq.sv
module phy_rst_lock_seq
    import phy_seq_pkg::*;
#(
    parameter int unsigned POLL_CYCLES = 20000,
    parameter int unsigned SB_CYCLES   = 5000,
    parameter int unsigned MAX_POLLS   = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        sideband_mode,
    output logic        cmd_req,
    output logic [1:0]  cmd_op,
    output logic [15:0] cmd_wdata,
    input  logic        cmd_done,
    input  logic        cmd_err,
    input  logic [15:0] cmd_rdata,
    output logic        phy_ready,
    output logic        phy_error,
    output logic [1:0]  fault_code,
    output logic        sb_pwrdn,
    output logic        sb_rst_n
);
    seq_state_e state;
    cmd_t       cmd;
    fault_e     fault_q;
    logic       poll_exp;
    logic       sb_exp;
    logic       tries_last;
    logic       lock_seen;
    logic       rd_unused;
    logic       poll_miss;

    assign cmd       = state_cmd(state);
    assign cmd_req   = cmd.req;
    assign cmd_op    = cmd.op;
    assign cmd_wdata = cmd.data;

    assign lock_seen  = cmd_rdata[LOCK_BIT];
    assign rd_unused  = ^(cmd_rdata & ~LOCK_MASK);
    assign poll_miss  = (state == S_STAT_RD) && cmd_done && !cmd_err && !lock_seen;
    assign fault_code = fault_q;

    phy_seq_delay #(.CYCLES(POLL_CYCLES)) u_poll_dly (
        .clk     (clk),
        .rst     (rst),
        .en      (state == S_WAIT),
        .expired (poll_exp)
    );

    phy_seq_delay #(.CYCLES(SB_CYCLES)) u_sb_dly (
        .clk     (clk),
        .rst     (rst),
        .en      (state == S_SB_HOLD),
        .expired (sb_exp)
    );

    phy_seq_tries #(.LIMIT(MAX_POLLS)) u_tries (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == S_IDLE),
        .inc  (poll_miss),
        .last (tries_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            phy_ready <= 1'b0;
            phy_error <= 1'b0;
            fault_q   <= FAULT_NONE;
            sb_pwrdn  <= 1'b1;
            sb_rst_n  <= 1'b1;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        phy_ready <= 1'b0;
                        phy_error <= 1'b0;
                        fault_q   <= FAULT_NONE;
                        if (sideband_mode) begin
                            sb_pwrdn <= 1'b0;
                            sb_rst_n <= 1'b0;
                            state    <= S_SB_HOLD;
                        end else begin
                            state <= S_RST_ADDR;
                        end
                    end
                end
                S_RST_ADDR: begin
                    if (cmd_done) begin
                        if (cmd_err) begin
                            phy_error <= 1'b1;
                            fault_q   <= FAULT_MASTER;
                            state     <= S_IDLE;
                        end else begin
                            state <= S_RST_WR;
                        end
                    end
                end
                S_RST_WR: state <= S_WAIT;
                S_WAIT: begin
                    if (poll_exp) state <= S_STAT_ADDR;
                end
                S_STAT_ADDR: begin
                    if (cmd_done) begin
                        if (cmd_err) begin
                            phy_error <= 1'b1;
                            fault_q   <= FAULT_MASTER;
                            state     <= S_IDLE;
                        end else begin
                            state <= S_STAT_RD;
                        end
                    end
                end
                S_STAT_RD: begin
                    if (cmd_done) begin
                        if (cmd_err) begin
                            phy_error <= 1'b1;
                            fault_q   <= FAULT_MASTER;
                            state     <= S_IDLE;
                        end else if (lock_seen) begin
                            phy_ready <= 1'b1;
                            state     <= S_IDLE;
                        end else if (tries_last) begin
                            phy_error <= 1'b1;
                            fault_q   <= FAULT_TIMEOUT;
                            state     <= S_IDLE;
                        end else begin
                            state <= S_WAIT;
                        end
                    end
                end
                S_SB_HOLD: begin
                    if (sb_exp) begin
                        sb_rst_n  <= 1'b1;
                        phy_ready <= 1'b1;
                        state     <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phy_seq_checks.sv
module phy_seq_checks
    import phy_seq_pkg::*;
#(
    parameter int unsigned SB_CYCLES = 5000
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_req,
    input logic [1:0]  cmd_op,
    input logic [15:0] cmd_wdata,
    input logic        cmd_done,
    input logic        cmd_err,
    input logic        phy_ready,
    input logic        phy_error,
    input logic [1:0]  fault_code,
    input logic        sb_pwrdn,
    input logic        sb_rst_n
);
    localparam int unsigned LW = $clog2(SB_CYCLES + 1) + 1;

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || sb_rst_n) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r9_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_done && cmd_op != OP_WR_POSTED)
        |=> (cmd_req && $stable(cmd_op) && $stable(cmd_wdata)));

    a_r2_posted_single: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_op == OP_WR_POSTED) |=> !cmd_req);

    a_r6_fault_abort: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_done && cmd_err)
        |=> (!cmd_req && phy_error && fault_code == FAULT_MASTER));

    a_r4_ready_excl: assert property (@(posedge clk) disable iff (rst)
        phy_ready |-> !phy_error);

    a_r4_quiet_on_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_ready) |-> !cmd_req);

    a_r7_pwrdn_clear: assert property (@(posedge clk) disable iff (rst)
        !sb_rst_n |-> !sb_pwrdn);

    a_r7_hold_bound: assert property (@(posedge clk) disable iff (rst)
        !sb_rst_n |-> (low_cnt < LW'(SB_CYCLES)));

    a_r7_release_len: assert property (@(posedge clk) disable iff (rst)
        $rose(sb_rst_n) |-> (low_cnt == LW'(SB_CYCLES) && phy_ready));

endmodule

bind phy_rst_lock_seq phy_seq_checks #(.SB_CYCLES(SB_CYCLES)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .cmd_req    (cmd_req),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .cmd_done   (cmd_done),
    .cmd_err    (cmd_err),
    .phy_ready  (phy_ready),
    .phy_error  (phy_error),
    .fault_code (fault_code),
    .sb_pwrdn   (sb_pwrdn),
    .sb_rst_n   (sb_rst_n)
);

// File: tb/phy_rst_lock_seq_test.sv
module phy_rst_lock_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int POLL = 4;
    localparam int SB   = 6;
    localparam int MAXP = 3;
    localparam int LAT  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sideband_mode = 1'b0;
    logic        cmd_req;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_wdata;
    logic        cmd_done;
    logic        cmd_err;
    logic [15:0] cmd_rdata;
    logic        phy_ready;
    logic        phy_error;
    logic [1:0]  fault_code;
    logic        sb_pwrdn;
    logic        sb_rst_n;

    phy_rst_lock_seq #(
        .POLL_CYCLES (POLL),
        .SB_CYCLES   (SB),
        .MAX_POLLS   (MAXP)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .sideband_mode (sideband_mode),
        .cmd_req       (cmd_req),
        .cmd_op        (cmd_op),
        .cmd_wdata     (cmd_wdata),
        .cmd_done      (cmd_done),
        .cmd_err       (cmd_err),
        .cmd_rdata     (cmd_rdata),
        .phy_ready     (phy_ready),
        .phy_error     (phy_error),
        .fault_code    (fault_code),
        .sb_pwrdn      (sb_pwrdn),
        .sb_rst_n      (sb_rst_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [1:0]  op;
        logic [15:0] data;
    } exp_cmd_t;

    exp_cmd_t exp_q[$];
    int       n_checks = 0;
    int       n_fails  = 0;
    longint   cyc      = 0;
    longint   last_ev  = 0;
    int       lock_at  = 0;
    int       err_at   = 0;
    int       n_reads  = 0;
    int       n_cmds   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    task automatic push(input logic [1:0] op, input logic [15:0] data);
        exp_cmd_t e;
        e.op = op;
        e.data = data;
        exp_q.push_back(e);
    endtask

    task automatic push_reset();
        push(2'b00, 16'h7F3F);
        push(2'b10, 16'h0001);
    endtask

    task automatic push_polls(input int n);
        for (int i = 0; i < n; i++) begin
            push(2'b00, 16'h2003);
            push(2'b01, 16'h0000);
        end
    endtask

    // Master model and scoreboard monitor
    initial begin
        logic [1:0]  op;
        logic [15:0] d;
        exp_cmd_t    e;
        string       tag;
        cmd_done  = 1'b0;
        cmd_err   = 1'b0;
        cmd_rdata = 16'h0000;
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            cmd_err  = 1'b0;
            if (!rst && cmd_req) begin
                op = cmd_op;
                d  = cmd_wdata;
                tag = (op == 2'b10 || d == 16'h7F3F) ? "R2" : "R3";
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected command", {op, d}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(op == e.op && d == e.data, tag, "command op/data",
                        {op, d}, {e.op, e.data});
                end
                if (op == 2'b00 && d == 16'h2003)
                    chk(cyc - last_ev == POLL + 1, "R3", "poll gap cycles",
                        cyc - last_ev, POLL + 1);
                if (op == 2'b10) begin
                    last_ev = cyc;
                end else begin
                    n_cmds++;
                    repeat (LAT) @(negedge clk);
                    if (op == 2'b01) begin
                        n_reads++;
                        cmd_rdata = (n_reads == lock_at) ? 16'h0006 : 16'hFFFD;
                    end
                    cmd_done = 1'b1;
                    cmd_err  = (n_cmds == err_at);
                    last_ev  = cyc;
                end
            end
        end
    end

    task automatic run_reg(input int lock_n, input int err_n, input bit poke,
                           input string tag, input bit exp_ready,
                           input logic [1:0] exp_code, input int exp_reads);
        int w;
        lock_at = lock_n;
        err_at  = err_n;
        n_reads = 0;
        n_cmds  = 0;
        @(negedge clk);
        start = 1'b1;
        sideband_mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(!phy_ready && !phy_error && fault_code == 2'b00, "R10", "flags cleared on start",
            {phy_ready, phy_error, fault_code}, 0);
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (POLL + 2) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!phy_ready && !phy_error && w < 500) begin
            @(negedge clk);
            w++;
        end
        repeat (POLL + LAT + 4) @(negedge clk);
        chk(phy_ready == exp_ready, tag, "phy_ready", phy_ready, exp_ready);
        chk(phy_error == !exp_ready, tag, "phy_error", phy_error, !exp_ready);
        chk(fault_code == exp_code, tag, "fault_code", fault_code, exp_code);
        chk(n_reads == exp_reads, tag, "read count", n_reads, exp_reads);
        chk(exp_q.size() == 0, tag, "commands left unissued", exp_q.size(), 0);
    endtask

    task automatic run_sb();
        int low;
        @(negedge clk);
        start = 1'b1;
        sideband_mode = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sideband_mode = 1'b0;
        chk(!sb_pwrdn && !sb_rst_n, "R7", "pwrdn and reset low together",
            {sb_pwrdn, sb_rst_n}, 0);
        chk(!phy_ready && !phy_error && fault_code == 2'b00, "R10", "flags cleared on sideband start",
            {phy_ready, phy_error, fault_code}, 0);
        low = 1;
        while (!sb_rst_n && low < 1000) begin
            @(negedge clk);
            if (!sb_rst_n) low++;
        end
        chk(low == SB, "R7", "reset low cycles", low, SB);
        chk(phy_ready && !phy_error && !sb_pwrdn, "R7", "ready with release",
            {phy_ready, phy_error, sb_pwrdn}, 3'b100);
        repeat (4) @(negedge clk);
        chk(!cmd_req && exp_q.size() == 0, "R7", "no commands in sideband mode", cmd_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!phy_ready && !phy_error && fault_code == 2'b00 && !cmd_req, "R1",
            "reset flags", {phy_ready, phy_error, fault_code, cmd_req}, 0);
        chk(sb_pwrdn && sb_rst_n, "R1", "reset sideband", {sb_pwrdn, sb_rst_n}, 2'b11);

        // R2 R4: lock on first read
        push_reset();
        push_polls(1);
        run_reg(1, 0, 1'b0, "R4", 1'b1, 2'b00, 1);
        chk(sb_pwrdn && sb_rst_n, "R7", "register mode leaves sideband", {sb_pwrdn, sb_rst_n}, 2'b11);

        // R8 + R4 boundary: lock on last allowed read with starts poked mid-run
        push_reset();
        push_polls(MAXP);
        run_reg(MAXP, 0, 1'b1, "R8", 1'b1, 2'b00, MAXP);

        // R5 timeout
        push_reset();
        push_polls(MAXP);
        run_reg(0, 0, 1'b0, "R5", 1'b0, 2'b01, MAXP);

        // R6 master fault on first command
        push(2'b00, 16'h7F3F);
        run_reg(0, 1, 1'b0, "R6", 1'b0, 2'b10, 0);

        // R6 master fault on second status address
        push_reset();
        push_polls(1);
        push(2'b00, 16'h2003);
        run_reg(0, 4, 1'b0, "R6", 1'b0, 2'b10, 1);

        // R7 sideband reset after an error
        run_sb();

        // Register mode after sideband keeps sideband state
        push_reset();
        push_polls(2);
        run_reg(2, 0, 1'b0, "R3", 1'b1, 2'b00, 2);
        chk(!sb_pwrdn && sb_rst_n, "R7", "sideband untouched by register mode",
            {sb_pwrdn, sb_rst_n}, 2'b01);

        summary();
        $finish;
    end
endmodule